// File: doc/BRIEF.md
# Hub Status-Change Interrupt Responder

This block holds the status-change bitmap of a USB hub and answers IN polls on the hub's interrupt endpoint. The hub itself and each downstream port raise a one-cycle change flag when something about them changes. A flag that arrives during a frame waits in a pending register. It moves into the reported bitmap at the frame's EOF2 marker, so that a transfer in the following frame carries it.

When the host polls, the block answers one cycle later. It returns a NAK when there is nothing to report, or the whole status byte with a one-cycle valid strobe. A reported change stays in the bitmap across polls and frames until the host clears that source. A clear takes effect at once and does not wait for a frame boundary. Until the hub is configured, the block reports nothing and discards any change it sees.

Token decoding, CRC and data toggle live outside this block.

Top module: `hub_chg_responder`

## Requirements
- R1: While reset is asserted, `rsp_nak_o` and `rsp_vld_o` are low and `rsp_byte_o` is zero.
- R2: A change flag raised between EOF2 markers is held in the pending register. It is not visible to polls until the next `eof2_i` pulse, and at that pulse it enters the bitmap.
- R3: While `cfg_i` is low, every poll is answered with NAK. Pending and reported changes are cleared, and change flags are discarded, so they do not appear after configuration.
- R4: Byte layout: bit 0 is the hub-level change, bit k (k = 1..4) is the change of port k, and bits 7..5 are always zero.
- R5: A poll made while the bitmap is all zero is answered with NAK.
- R6: A poll made in cycle t gets exactly one response in cycle t+1. That response is either `rsp_nak_o` or `rsp_vld_o`, never both, and is one cycle wide. A poll with any of bits 4..0 set returns the full byte. `rsp_byte_o` is zero whenever `rsp_vld_o` is low.
- R7: A reported bit remains set across any number of polls and EOF2 markers until its source is cleared.
- R8: A clear request (`clr_i`, same bit order as R4) removes that bit from the bitmap on the next cycle without waiting for EOF2. It leaves the other bits unchanged. A change for the same source already pending still enters the bitmap at the next EOF2.
- R9: A change flag raised in the same cycle as `eof2_i` enters the bitmap at that marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 1 | Hub is enumerated and configured |
| hub_chg_i | input | 1 | One-cycle hub-level change flag |
| port_chg_i | input | NUM_PORTS | One-cycle per-port change flags, bit 0 = port 1 |
| eof2_i | input | 1 | End-of-frame EOF2 marker pulse |
| clr_i | input | NUM_PORTS+1 | Per-source clear request, layout as R4 |
| in_poll_i | input | 1 | IN token addressed to the interrupt endpoint |
| rsp_nak_o | output | 1 | NAK response strobe |
| rsp_vld_o | output | 1 | Data response strobe |
| rsp_byte_o | output | BYTE_W | Status-change byte, valid with `rsp_vld_o` |

## Verification
A wrong bitmap bit shows up at the first poll that follows: a byte whose value differs from the expected one, or a NAK where data was due (or the reverse). If the pending register is wrong, the error appears only at the first poll after the next EOF2 marker. The bench therefore polls both before and after each marker. A fault in the response timing appears as a strobe one cycle early or late, or as a missing or extra strobe. The scoreboard catches these because it checks the cycle in which each response arrives.

// File: rtl/hubchg_pkg.sv
package hubchg_pkg;

   // Kind of answer the responder gives for one poll.
   typedef enum logic [1:0] {
      RSP_NONE = 2'd0,
      RSP_NAK  = 2'd1,
      RSP_DATA = 2'd2
   } rsp_kind_e;

   // Number of change sources: the hub itself plus each port.
   function automatic int src_count(input int ports);
      return ports + 1;
   endfunction

endpackage

// File: rtl/hubchg_pending.sv
// Per-source pending register: latches changes that arrive within a frame
// and empties itself at the EOF2 marker, when the bitmap takes them over.
module hubchg_pending #(
   parameter int SRC = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_i,
   input  logic           eof2_i,
   input  logic [SRC-1:0] chg_i,
   output logic [SRC-1:0] pend_o
);

   for (genvar s = 0; s < SRC; s++) begin : g_src
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pend_q <= 1'b0;
         else if (!cfg_i)  pend_q <= 1'b0;
         else if (eof2_i)  pend_q <= 1'b0;
         else if (chg_i[s]) pend_q <= 1'b1;
      end
      assign pend_o[s] = pend_q;
   end

endmodule

// File: rtl/hubchg_bitmap.sv
// Reported bitmap: loaded from the pending register (and from any
// change coincident with the marker) at EOF2, cleared per source at once.
module hubchg_bitmap #(
   parameter int SRC = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_i,
   input  logic           eof2_i,
   input  logic [SRC-1:0] chg_i,
   input  logic [SRC-1:0] pend_i,
   input  logic [SRC-1:0] clr_i,
   output logic [SRC-1:0] bm_o
);

   for (genvar s = 0; s < SRC; s++) begin : g_src
      logic bit_q;
      logic kept;
      logic loaded;

      // A clear removes the old value; a new change still lands.
      assign kept   = bit_q & ~clr_i[s];
      assign loaded = pend_i[s] | chg_i[s];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bit_q <= 1'b0;
         else if (!cfg_i) bit_q <= 1'b0;
         else if (eof2_i) bit_q <= kept | loaded;
         else             bit_q <= kept;
      end
      assign bm_o[s] = bit_q;
   end

endmodule

// File: rtl/hubchg_responder.sv
// Answers an IN poll one cycle later with NAK or the status byte.
module hubchg_responder
   import hubchg_pkg::*;
#(
   parameter int SRC    = 5,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_i,
   input  logic              poll_i,
   input  logic [SRC-1:0]    bm_i,
   output logic              nak_o,
   output logic              vld_o,
   output logic [BYTE_W-1:0] byte_o
);

   logic [BYTE_W-1:0] byte_d;
   rsp_kind_e         kind_d;
   rsp_kind_e         kind_q;
   logic [BYTE_W-1:0] byte_q;

   // Source bits in the low positions, reserved bits tied to zero.
   for (genvar b = 0; b < BYTE_W; b++) begin : g_byte
      if (b < SRC) begin : g_live
         assign byte_d[b] = bm_i[b];
      end else begin : g_rsvd
         assign byte_d[b] = 1'b0;
      end
   end

   always_comb begin
      if (!poll_i)                   kind_d = RSP_NONE;
      else if (!cfg_i || bm_i == '0) kind_d = RSP_NAK;
      else                           kind_d = RSP_DATA;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= RSP_NONE;
         byte_q <= '0;
      end else begin
         kind_q <= kind_d;
         byte_q <= (kind_d == RSP_DATA) ? byte_d : '0;
      end
   end

   assign nak_o  = (kind_q == RSP_NAK);
   assign vld_o  = (kind_q == RSP_DATA);
   assign byte_o = byte_q;

endmodule

// File: rtl/hub_chg_responder.sv
module hub_chg_responder
   import hubchg_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int BYTE_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_i,
   input  logic                 hub_chg_i,
   input  logic [NUM_PORTS-1:0] port_chg_i,
   input  logic                 eof2_i,
   input  logic [NUM_PORTS:0]   clr_i,
   input  logic                 in_poll_i,
   output logic                 rsp_nak_o,
   output logic                 rsp_vld_o,
   output logic [BYTE_W-1:0]    rsp_byte_o
);

   localparam int SRC = src_count(NUM_PORTS);

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("hub_chg_responder: NUM_PORTS must be at least 1");
   end
   if (SRC > BYTE_W) begin : g_bad_width
      $error("hub_chg_responder: BYTE_W too narrow for NUM_PORTS+1 sources");
   end

   logic [SRC-1:0] chg;
   logic [SRC-1:0] pend;
   logic [SRC-1:0] bm;

   assign chg = {port_chg_i, hub_chg_i};

   hubchg_pending #(.SRC(SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_i  (cfg_i),
      .eof2_i (eof2_i),
      .chg_i  (chg),
      .pend_o (pend)
   );

   hubchg_bitmap #(.SRC(SRC)) u_bm (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_i  (cfg_i),
      .eof2_i (eof2_i),
      .chg_i  (chg),
      .pend_i (pend),
      .clr_i  (clr_i),
      .bm_o   (bm)
   );

   hubchg_responder #(.SRC(SRC), .BYTE_W(BYTE_W)) u_rsp (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_i  (cfg_i),
      .poll_i (in_poll_i),
      .bm_i   (bm),
      .nak_o  (rsp_nak_o),
      .vld_o  (rsp_vld_o),
      .byte_o (rsp_byte_o)
   );

endmodule

// File: rtl/hub_chg_responder_chk.sv
module hub_chg_responder_chk #(
   parameter int SRC    = 5,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_i,
   input logic              eof2_i,
   input logic [SRC-1:0]    clr_i,
   input logic              in_poll_i,
   input logic [SRC-1:0]    bm,
   input logic              rsp_nak_o,
   input logic              rsp_vld_o,
   input logic [BYTE_W-1:0] rsp_byte_o
);

   // R6: never both answers at once
   a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_nak_o && rsp_vld_o));

   // R6: an answer only follows a poll
   a_r6_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_nak_o || rsp_vld_o) |-> $past(in_poll_i));

   // R6: a poll is always answered next cycle
   a_r6_answered: assert property (@(posedge clk) disable iff (!rst_n)
      in_poll_i |=> (rsp_nak_o || rsp_vld_o));

   // R4: reserved bits stay zero
   a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld_o |-> (rsp_byte_o >> SRC) == '0);

   // R5: data is only sent when something is set
   a_r5_data_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld_o |-> rsp_byte_o != '0);

   // R3: unconfigured polls get NAK
   a_r3_nak_unconf: assert property (@(posedge clk) disable iff (!rst_n)
      (in_poll_i && !cfg_i) |=> rsp_nak_o);

   // R3: unconfigured hub holds an empty bitmap
   a_r3_unconf_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_i |=> bm == '0);

   // R8: a mid-frame clear drops the bit on the next cycle
   a_r8_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
      (!eof2_i && clr_i != '0) |=> (bm & $past(clr_i)) == '0);

   // R7: bitmap holds between markers when nothing clears it
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i && !eof2_i && clr_i == '0) |=> $stable(bm));

endmodule

bind hub_chg_responder hub_chg_responder_chk #(.SRC(SRC), .BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_i      (cfg_i),
   .eof2_i     (eof2_i),
   .clr_i      (clr_i),
   .in_poll_i  (in_poll_i),
   .bm         (bm),
   .rsp_nak_o  (rsp_nak_o),
   .rsp_vld_o  (rsp_vld_o),
   .rsp_byte_o (rsp_byte_o)
);

// File: tb/hub_chg_responder_tb.sv
module hub_chg_responder_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_i = 1'b0;
   logic       hub_chg_i = 1'b0;
   logic [3:0] port_chg_i = '0;
   logic       eof2_i = 1'b0;
   logic [4:0] clr_i = '0;
   logic       in_poll_i = 1'b0;
   logic       rsp_nak_o;
   logic       rsp_vld_o;
   logic [7:0] rsp_byte_o;

   always #2 clk = ~clk;   // 250 MHz

   hub_chg_responder u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .hub_chg_i(hub_chg_i),
      .port_chg_i(port_chg_i), .eof2_i(eof2_i), .clr_i(clr_i),
      .in_poll_i(in_poll_i), .rsp_nak_o(rsp_nak_o), .rsp_vld_o(rsp_vld_o),
      .rsp_byte_o(rsp_byte_o)
   );

   typedef struct {
      logic       nak;
      logic [7:0] data;
      int         due;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc = 0;
   bit   done = 0;

   // Reference model, written from the requirements
   logic [4:0] m_bm = '0;
   logic [4:0] m_pend = '0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare each response as it appears
   always @(negedge clk) begin
      if (rst_n && (rsp_nak_o || rsp_vld_o)) begin
         n_chk++;
         if (q.size() == 0) begin
            n_bad++;
            $display("FAIL R6: unexpected response nak=%0b vld=%0b byte=%02h, expected none",
                     rsp_nak_o, rsp_vld_o, rsp_byte_o);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (cyc != e.due) begin
               n_bad++;
               $display("FAIL R6: response in cycle %0d, expected cycle %0d", cyc, e.due);
            end else if (e.nak && !(rsp_nak_o && !rsp_vld_o)) begin
               n_bad++;
               $display("FAIL %s: got nak=%0b vld=%0b byte=%02h, expected NAK",
                        e.tag, rsp_nak_o, rsp_vld_o, rsp_byte_o);
            end else if (!e.nak && !(rsp_vld_o && !rsp_nak_o && rsp_byte_o == e.data)) begin
               n_bad++;
               $display("FAIL %s: got nak=%0b vld=%0b byte=%02h, expected data %02h",
                        e.tag, rsp_nak_o, rsp_vld_o, rsp_byte_o, e.data);
            end
         end
      end
   end

   // One cycle of stimulus, with the model updated alongside
   task automatic step(input logic [4:0] chg, input logic eof, input logic [4:0] clr,
                       input logic poll, input string tag);
      if (poll) begin
         exp_t e;
         e.nak  = (!cfg_i || m_bm == '0);
         e.data = e.nak ? 8'h00 : {3'b000, m_bm};
         e.due  = cyc + 1;
         e.tag  = tag;
         q.push_back(e);
      end
      hub_chg_i  = chg[0];
      port_chg_i = chg[4:1];
      eof2_i     = eof;
      clr_i      = clr;
      in_poll_i  = poll;
      if (!cfg_i) begin
         m_bm   = '0;
         m_pend = '0;
      end else if (eof) begin
         m_bm   = (m_bm & ~clr) | m_pend | chg;
         m_pend = '0;
      end else begin
         m_bm   = m_bm & ~clr;
         m_pend = m_pend | chg;
      end
      @(negedge clk);
      hub_chg_i = 1'b0; port_chg_i = '0; eof2_i = 1'b0; clr_i = '0; in_poll_i = 1'b0;
   endtask

   task automatic poll(input string tag);
      step(5'h00, 1'b0, 5'h00, 1'b1, tag);
   endtask
   task automatic change(input logic [4:0] m);
      step(m, 1'b0, 5'h00, 1'b0, "");
   endtask
   task automatic marker(input logic [4:0] m);
      step(m, 1'b1, 5'h00, 1'b0, "");
   endtask
   task automatic clear(input logic [4:0] m);
      step(5'h00, 1'b0, m, 1'b0, "");
   endtask
   task automatic set_cfg(input logic v);
      cfg_i = v;
      if (!v) begin m_bm = '0; m_pend = '0; end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (rsp_nak_o !== 1'b0 || rsp_vld_o !== 1'b0 || rsp_byte_o !== 8'h00) begin
         n_bad++;
         $display("FAIL R1: reset outputs nak=%0b vld=%0b byte=%02h, expected 0/0/00",
                  rsp_nak_o, rsp_vld_o, rsp_byte_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      set_cfg(1'b1);

      poll("R5 empty bitmap");
      change(5'h04);                 // port 2
      poll("R2 pending not visible");
      marker(5'h00);
      poll("R2 R4 port 2 at EOF2");
      poll("R7 repeat poll");
      marker(5'h00);
      poll("R7 across marker");
      change(5'h01);                 // hub
      marker(5'h00);
      poll("R4 hub bit 0");
      clear(5'h04);
      poll("R8 clear mid-frame");
      change(5'h10);                 // port 4
      clear(5'h10);
      marker(5'h00);
      poll("R8 pending survives clear");
      marker(5'h08);                 // port 3 with the marker
      poll("R9 change at marker");
      clear(5'h19);
      poll("R5 all cleared");
      change(5'h1F);
      marker(5'h00);
      poll("R4 all sources");
      poll("R6 back-to-back 1");
      poll("R6 back-to-back 2");
      set_cfg(1'b0);
      poll("R3 unconfigured NAK");
      change(5'h02);
      marker(5'h00);
      set_cfg(1'b1);
      marker(5'h00);
      poll("R3 change discarded");
      change(5'h02);
      marker(5'h00);
      poll("R3 R4 port 1 after reconfig");

      repeat (4) @(negedge clk);
      n_chk++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R6: %0d responses missing, expected 0", q.size());
      end
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL R6: watchdog expired, actual hung, expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule